// File: doc/BRIEF.md
# Speculative Way Predictor for a Two-Thread L1 Data Cache

This block is the fast-path hit predictor that sits beside the data array of a first-level data cache shared by two hardware threads. For every way of every set it keeps a short tag cut from the linear address, the number of the thread that filled the line, and a valid flag. When a load arrives, the block reads the indexed set and compares the short tag in all ways at once. In the same cycle it reports a speculative hit or miss and the predicted way. The full physical tag check runs later, elsewhere.

Whether a line brought in by one thread may hit for the other depends on a mode setting and on a context flag. In shared mode the owner thread must always match. In adaptive mode, which is the mode after reset, the block tracks each thread's page-table base and paging mode. When both threads have the same pair, the two threads use the same translations, so the owner comparison is dropped and a short-tag match is enough. A fill writes one chosen way. A context update replaces one thread's base and paging mode.

Top module: `wp_fastpath`

## Requirements
- R1: The set index is linear-address bits 10..6 and the short tag is bits 15..11. Address bits outside 15..6 have no effect on a lookup. A hit requires a valid entry in the indexed set whose stored short tag equals the request's tag.
- R2: A fill writes valid=1, the fill thread and the fill address's short tag into way `fill_way_i` of the indexed set, replacing what was there. A lookup in the fill cycle sees the old contents. A lookup from the next cycle sees the new contents.
- R3: In shared mode a hit also requires the stored thread to equal `lk_tid_i`.
- R4: In adaptive mode, while `ctx_same_o` is 1, the stored thread is not compared.
- R5: In adaptive mode, while `ctx_same_o` is 0, the stored thread must match, exactly as in shared mode.
- R6: `ctx_same_o` is recomputed on each context write. It is 1 when both threads' bases and paging modes are equal and 0 otherwise. It changes only in the cycle after a write, and a lookup in the write cycle uses the old value.
- R7: The mode register resets to adaptive (0). A config write loads `cfg_shared_i`, where 1 selects shared mode. The new mode applies from the next cycle.
- R8: When several ways match, the lowest-numbered way is predicted. On a miss `pred_way_o` is 0.
- R9: After reset every entry is invalid, so every lookup misses. Both bases and paging modes reset to 0, so `ctx_same_o` is 1.
- R10: Without `lk_valid_i`, `pred_hit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Load the mode register |
| cfg_shared_i | input | 1 | New mode: 1 shared, 0 adaptive |
| lk_valid_i | input | 1 | Load lookup request |
| lk_addr_i | input | 32 | Load linear address |
| lk_tid_i | input | 1 | Requesting thread |
| fill_valid_i | input | 1 | Write one entry |
| fill_addr_i | input | 32 | Linear address of the filled line |
| fill_way_i | input | 2 | Way to write |
| fill_tid_i | input | 1 | Thread that owns the fill |
| ctx_wr_i | input | 1 | Context update strobe |
| ctx_tid_i | input | 1 | Thread whose context changes |
| ctx_base_i | input | 20 | New page-table base |
| ctx_pmode_i | input | 2 | New paging mode |
| pred_hit_o | output | 1 | Speculative hit |
| pred_way_o | output | 2 | Predicted way |
| ctx_same_o | output | 1 | Both thread contexts identical |

## Verification
The assertions check four things on every cycle. There is no hit without a request, and the way reads zero on a miss. The context flag holds steady between context writes. A lookup for the address and thread of the previous cycle's fill always hits. Only the bench's scenarios can show the rest: which way wins when several match, how the thread comparison turns on and off across the two modes and across context changes, and the one-cycle lag of fills, mode writes and context writes against a lookup in the same cycle.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
    typedef enum logic {
        WP_ADAPTIVE = 1'b0,
        WP_SHARED   = 1'b1
    } wp_mode_e;

    localparam int WP_NUM_THREADS = 2;
    localparam int WP_TID_W       = $clog2(WP_NUM_THREADS);

    typedef logic [WP_TID_W-1:0] wp_tid_t;
endpackage

// File: rtl/wp_tag_store.sv
`timescale 1ns/1ps
module wp_tag_store
    import wp_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SETS   = 32,
    parameter int PTAG_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(SETS)-1:0]         wr_set,
    input  logic [$clog2(WAYS)-1:0]         wr_way,
    input  logic [PTAG_W-1:0]               wr_ptag,
    input  wp_tid_t                         wr_tid,
    input  logic [$clog2(SETS)-1:0]         rd_set,
    output logic [WAYS-1:0]                 rd_valid,
    output wp_tid_t [WAYS-1:0]              rd_tid,
    output logic [WAYS-1:0][PTAG_W-1:0]     rd_ptag
);
    typedef struct packed {
        logic                valid;
        wp_tid_t             tid;
        logic [PTAG_W-1:0]   ptag;
    } entry_t;

    typedef struct packed {
        entry_t [SETS-1:0][WAYS-1:0] mem;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_set][wr_way].valid = 1'b1;
            st_d.mem[wr_set][wr_way].tid   = wr_tid;
            st_d.mem[wr_set][wr_way].ptag  = wr_ptag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_valid[w] = st_q.mem[rd_set][w].valid;
        assign rd_tid[w]   = st_q.mem[rd_set][w].tid;
        assign rd_ptag[w]  = st_q.mem[rd_set][w].ptag;
    end
endmodule

// File: rtl/wp_ctx_track.sv
`timescale 1ns/1ps
module wp_ctx_track
    import wp_pkg::*;
#(
    parameter int BASE_W  = 20,
    parameter int PMODE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_i,
    input  wp_mode_e           cfg_mode_i,
    input  logic               upd_i,
    input  wp_tid_t            upd_tid_i,
    input  logic [BASE_W-1:0]  upd_base_i,
    input  logic [PMODE_W-1:0] upd_pmode_i,
    output wp_mode_e           mode_o,
    output logic               same_o
);
    typedef struct packed {
        wp_mode_e                                mode;
        logic [WP_NUM_THREADS-1:0][BASE_W-1:0]   base;
        logic [WP_NUM_THREADS-1:0][PMODE_W-1:0]  pmode;
        logic                                    same;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr_i) begin
            st_d.mode = cfg_mode_i;
        end
        if (upd_i) begin
            st_d.base[upd_tid_i]  = upd_base_i;
            st_d.pmode[upd_tid_i] = upd_pmode_i;
            st_d.same = (st_d.base[0] == st_d.base[1]) &&
                        (st_d.pmode[0] == st_d.pmode[1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= WP_ADAPTIVE;
            st_q.base  <= '0;
            st_q.pmode <= '0;
            st_q.same  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign same_o = st_q.same;
endmodule

// File: rtl/wp_way_select.sv
`timescale 1ns/1ps
module wp_way_select
    import wp_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int PTAG_W = 5
) (
    input  logic [WAYS-1:0]             ent_valid,
    input  wp_tid_t [WAYS-1:0]          ent_tid,
    input  logic [WAYS-1:0][PTAG_W-1:0] ent_ptag,
    input  logic                        req_valid,
    input  wp_tid_t                     req_tid,
    input  logic [PTAG_W-1:0]           req_ptag,
    input  logic                        ignore_tid,
    output logic                        hit_o,
    output logic [$clog2(WAYS)-1:0]     way_o
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        logic tag_eq;
        logic tid_ok;
        assign tag_eq   = ent_valid[w] && (ent_ptag[w] == req_ptag);
        assign tid_ok   = ignore_tid || (ent_tid[w] == req_tid);
        assign match[w] = req_valid && tag_eq && tid_ok;
    end

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way_o = WAY_W'(w);
        end
    end

    assign hit_o = |match;
endmodule

// File: rtl/wp_fastpath.sv
`timescale 1ns/1ps
module wp_fastpath
    import wp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WAYS     = 4,
    parameter int SETS     = 32,
    parameter int IDX_LSB  = 6,
    parameter int PTAG_LSB = 11,
    parameter int PTAG_W   = 5,
    parameter int BASE_W   = 20,
    parameter int PMODE_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_i,
    input  logic                     cfg_shared_i,
    input  logic                     lk_valid_i,
    input  logic [ADDR_W-1:0]        lk_addr_i,
    input  logic                     lk_tid_i,
    input  logic                     fill_valid_i,
    input  logic [ADDR_W-1:0]        fill_addr_i,
    input  logic [$clog2(WAYS)-1:0]  fill_way_i,
    input  logic                     fill_tid_i,
    input  logic                     ctx_wr_i,
    input  logic                     ctx_tid_i,
    input  logic [BASE_W-1:0]        ctx_base_i,
    input  logic [PMODE_W-1:0]       ctx_pmode_i,
    output logic                     pred_hit_o,
    output logic [$clog2(WAYS)-1:0]  pred_way_o,
    output logic                     ctx_same_o
);
    localparam int IDX_W    = $clog2(SETS);
    localparam int PTAG_MSB = PTAG_LSB + PTAG_W - 1;
    localparam int IDX_MSB  = IDX_LSB + IDX_W - 1;

    logic [IDX_W-1:0]            lk_set, fill_set;
    logic [PTAG_W-1:0]           lk_ptag, fill_ptag;
    logic [WAYS-1:0]             rd_valid;
    wp_tid_t [WAYS-1:0]          rd_tid;
    logic [WAYS-1:0][PTAG_W-1:0] rd_ptag;
    wp_mode_e                    mode;
    logic                        same;
    logic                        ignore_tid;
    logic                        unused_addr_bits;

    assign lk_set    = lk_addr_i[IDX_MSB:IDX_LSB];
    assign lk_ptag   = lk_addr_i[PTAG_MSB:PTAG_LSB];
    assign fill_set  = fill_addr_i[IDX_MSB:IDX_LSB];
    assign fill_ptag = fill_addr_i[PTAG_MSB:PTAG_LSB];

    assign unused_addr_bits = ^{lk_addr_i[ADDR_W-1:PTAG_MSB+1], lk_addr_i[IDX_LSB-1:0],
                                fill_addr_i[ADDR_W-1:PTAG_MSB+1], fill_addr_i[IDX_LSB-1:0]};

    wp_tag_store #(
        .WAYS   (WAYS),
        .SETS   (SETS),
        .PTAG_W (PTAG_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_valid_i),
        .wr_set   (fill_set),
        .wr_way   (fill_way_i),
        .wr_ptag  (fill_ptag),
        .wr_tid   (wp_tid_t'(fill_tid_i)),
        .rd_set   (lk_set),
        .rd_valid (rd_valid),
        .rd_tid   (rd_tid),
        .rd_ptag  (rd_ptag)
    );

    wp_ctx_track #(
        .BASE_W  (BASE_W),
        .PMODE_W (PMODE_W)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_mode_i  (wp_mode_e'(cfg_shared_i)),
        .upd_i       (ctx_wr_i),
        .upd_tid_i   (wp_tid_t'(ctx_tid_i)),
        .upd_base_i  (ctx_base_i),
        .upd_pmode_i (ctx_pmode_i),
        .mode_o      (mode),
        .same_o      (same)
    );

    assign ignore_tid = (mode == WP_ADAPTIVE) && same;

    wp_way_select #(
        .WAYS   (WAYS),
        .PTAG_W (PTAG_W)
    ) u_sel (
        .ent_valid  (rd_valid),
        .ent_tid    (rd_tid),
        .ent_ptag   (rd_ptag),
        .req_valid  (lk_valid_i),
        .req_tid    (wp_tid_t'(lk_tid_i)),
        .req_ptag   (lk_ptag),
        .ignore_tid (ignore_tid),
        .hit_o      (pred_hit_o),
        .way_o      (pred_way_o)
    );

    assign ctx_same_o = same;
endmodule

// File: rtl/wp_fastpath_chk.sv
`timescale 1ns/1ps
module wp_fastpath_chk #(
    parameter int ADDR_W   = 32,
    parameter int WAYS     = 4,
    parameter int SETS     = 32,
    parameter int IDX_LSB  = 6,
    parameter int PTAG_LSB = 11,
    parameter int PTAG_W   = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lk_valid_i,
    input logic [ADDR_W-1:0]       lk_addr_i,
    input logic                    lk_tid_i,
    input logic                    fill_valid_i,
    input logic [ADDR_W-1:0]       fill_addr_i,
    input logic                    fill_tid_i,
    input logic                    ctx_wr_i,
    input logic                    pred_hit_o,
    input logic [$clog2(WAYS)-1:0] pred_way_o,
    input logic                    ctx_same_o
);
    localparam int IDX_MSB  = IDX_LSB + $clog2(SETS) - 1;
    localparam int PTAG_MSB = PTAG_LSB + PTAG_W - 1;

    logic unused_chk_bits;
    assign unused_chk_bits = ^{lk_addr_i[ADDR_W-1:PTAG_MSB+1], lk_addr_i[IDX_LSB-1:0],
                               fill_addr_i[ADDR_W-1:PTAG_MSB+1], fill_addr_i[IDX_LSB-1:0]};

    a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |-> !pred_hit_o);

    a_r8_miss_way_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit_o |-> (pred_way_o == '0));

    a_r6_ctx_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_wr_i |=> $stable(ctx_same_o));

    a_r2_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid_i |=>
            (!(lk_valid_i &&
               lk_addr_i[IDX_MSB:IDX_LSB]   == $past(fill_addr_i[IDX_MSB:IDX_LSB]) &&
               lk_addr_i[PTAG_MSB:PTAG_LSB] == $past(fill_addr_i[PTAG_MSB:PTAG_LSB]) &&
               lk_tid_i == $past(fill_tid_i)) || pred_hit_o));
endmodule

bind wp_fastpath wp_fastpath_chk #(
    .ADDR_W   (ADDR_W),
    .WAYS     (WAYS),
    .SETS     (SETS),
    .IDX_LSB  (IDX_LSB),
    .PTAG_LSB (PTAG_LSB),
    .PTAG_W   (PTAG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid_i   (lk_valid_i),
    .lk_addr_i    (lk_addr_i),
    .lk_tid_i     (lk_tid_i),
    .fill_valid_i (fill_valid_i),
    .fill_addr_i  (fill_addr_i),
    .fill_tid_i   (fill_tid_i),
    .ctx_wr_i     (ctx_wr_i),
    .pred_hit_o   (pred_hit_o),
    .pred_way_o   (pred_way_o),
    .ctx_same_o   (ctx_same_o)
);

// File: tb/tb_wp_fastpath.sv
`timescale 1ns/1ps
module tb_wp_fastpath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_i = 1'b0, cfg_shared_i = 1'b0;
    logic        lk_valid_i = 1'b0, lk_tid_i = 1'b0;
    logic [31:0] lk_addr_i = '0;
    logic        fill_valid_i = 1'b0, fill_tid_i = 1'b0;
    logic [31:0] fill_addr_i = '0;
    logic [1:0]  fill_way_i = '0;
    logic        ctx_wr_i = 1'b0, ctx_tid_i = 1'b0;
    logic [19:0] ctx_base_i = '0;
    logic [1:0]  ctx_pmode_i = '0;
    logic        pred_hit_o, ctx_same_o;
    logic [1:0]  pred_way_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wp_fastpath dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_shared_i(cfg_shared_i),
        .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_tid_i(lk_tid_i),
        .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i), .fill_way_i(fill_way_i),
        .fill_tid_i(fill_tid_i), .ctx_wr_i(ctx_wr_i), .ctx_tid_i(ctx_tid_i),
        .ctx_base_i(ctx_base_i), .ctx_pmode_i(ctx_pmode_i),
        .pred_hit_o(pred_hit_o), .pred_way_o(pred_way_o), .ctx_same_o(ctx_same_o)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        tid;
        logic        hit;
        logic [1:0]  way;
    } vec_t;

    // Shared mode, after fills: set3/tag5 way2 t0, set3/tag5 way1 t1,
    // set3/tag9 way0 t0, set10/tag31 way3 t1, set10/tag31 way0 t1
    localparam vec_t VECS [9] = '{
        '{32'h0000_28C0, 1'b0, 1'b1, 2'd2},
        '{32'h0000_28C0, 1'b1, 1'b1, 2'd1},
        '{32'h0000_48C0, 1'b0, 1'b1, 2'd0},
        '{32'h0000_48C0, 1'b1, 1'b0, 2'd0},
        '{32'h0000_FA80, 1'b1, 1'b1, 2'd0},
        '{32'h0000_FA80, 1'b0, 1'b0, 2'd0},
        '{32'h1234_28FF, 1'b0, 1'b1, 2'd2},
        '{32'h0000_2900, 1'b0, 1'b0, 2'd0},
        '{32'h0000_30C0, 1'b0, 1'b0, 2'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] a, input logic t, input logic eh,
                        input logic [1:0] ew, input string req);
        @(negedge clk);
        lk_valid_i = 1'b1; lk_addr_i = a; lk_tid_i = t;
        #1;
        chk({req, " hit"}, 32'(pred_hit_o), 32'(eh));
        chk({req, " way"}, 32'(pred_way_o), 32'(ew));
        lk_valid_i = 1'b0;
    endtask

    task automatic do_fill(input logic [31:0] a, input logic [1:0] w, input logic t);
        @(negedge clk);
        fill_valid_i = 1'b1; fill_addr_i = a; fill_way_i = w; fill_tid_i = t;
        @(negedge clk);
        fill_valid_i = 1'b0;
    endtask

    task automatic ctx_write(input logic t, input logic [19:0] b, input logic [1:0] m);
        @(negedge clk);
        ctx_wr_i = 1'b1; ctx_tid_i = t; ctx_base_i = b; ctx_pmode_i = m;
        @(negedge clk);
        ctx_wr_i = 1'b0;
    endtask

    task automatic cfg(input logic s);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_shared_i = s;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk("R9 ctx_same after reset", 32'(ctx_same_o), 32'd1);
        look(32'h0000_28C0, 1'b0, 1'b0, 2'd0, "R9 empty lookup");

        cfg(1'b1);
        do_fill(32'h0000_28C0, 2'd2, 1'b0);
        do_fill(32'h0000_28C0, 2'd1, 1'b1);
        do_fill(32'h0000_48C0, 2'd0, 1'b0);
        do_fill(32'h0000_FA80, 2'd3, 1'b1);
        do_fill(32'h0000_FA80, 2'd0, 1'b1);

        // R1 R3 R8: vector table in shared mode
        for (int i = 0; i < 9; i++) begin
            look(VECS[i].addr, VECS[i].tid, VECS[i].hit, VECS[i].way,
                 $sformatf("R1 R3 R8 vec%0d", i));
        end

        // R10: address of a valid entry without a request
        @(negedge clk);
        lk_valid_i = 1'b0; lk_addr_i = 32'h0000_28C0; lk_tid_i = 1'b0;
        #1;
        chk("R10 idle no hit", 32'(pred_hit_o), 32'd0);

        // R7 R4: adaptive mode, identical contexts
        cfg(1'b0);
        look(32'h0000_48C0, 1'b1, 1'b1, 2'd0, "R4 R7 cross-thread hit");
        look(32'h0000_FA80, 1'b0, 1'b1, 2'd0, "R4 cross-thread hit");
        look(32'h0000_28C0, 1'b0, 1'b1, 2'd1, "R4 R8 lowest way");

        // R6: context write with same-cycle lookup uses old flag
        @(negedge clk);
        ctx_wr_i = 1'b1; ctx_tid_i = 1'b1; ctx_base_i = 20'h00123; ctx_pmode_i = 2'd0;
        lk_valid_i = 1'b1; lk_addr_i = 32'h0000_48C0; lk_tid_i = 1'b1;
        #1;
        chk("R6 same-cycle old hit", 32'(pred_hit_o), 32'd1);
        chk("R6 flag unchanged in write cycle", 32'(ctx_same_o), 32'd1);
        @(negedge clk);
        ctx_wr_i = 1'b0;
        #1;
        chk("R6 flag differs after base write", 32'(ctx_same_o), 32'd0);
        chk("R5 thread compared again", 32'(pred_hit_o), 32'd0);
        lk_valid_i = 1'b0;

        look(32'h0000_28C0, 1'b1, 1'b1, 2'd1, "R5 own way t1");
        look(32'h0000_28C0, 1'b0, 1'b1, 2'd2, "R5 own way t0");

        ctx_write(1'b0, 20'h00123, 2'd0);
        chk("R6 flag equal bases", 32'(ctx_same_o), 32'd1);
        look(32'h0000_48C0, 1'b1, 1'b1, 2'd0, "R6 R4 shared again");

        ctx_write(1'b0, 20'h00123, 2'd1);
        chk("R6 flag paging mode differs", 32'(ctx_same_o), 32'd0);
        look(32'h0000_48C0, 1'b1, 1'b0, 2'd0, "R6 R5 mode mismatch miss");

        ctx_write(1'b1, 20'h00123, 2'd1);
        chk("R6 flag equal again", 32'(ctx_same_o), 32'd1);

        // R7: config write to shared takes effect next cycle
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_shared_i = 1'b1;
        lk_valid_i = 1'b1; lk_addr_i = 32'h0000_48C0; lk_tid_i = 1'b1;
        #1;
        chk("R7 old mode in write cycle", 32'(pred_hit_o), 32'd1);
        @(negedge clk);
        cfg_wr_i = 1'b0;
        #1;
        chk("R7 R3 shared ignores same ctx", 32'(pred_hit_o), 32'd0);
        lk_valid_i = 1'b0;

        // R2: fill and lookup in the same cycle
        @(negedge clk);
        fill_valid_i = 1'b1; fill_addr_i = 32'h0000_1500; fill_way_i = 2'd1; fill_tid_i = 1'b0;
        lk_valid_i = 1'b1; lk_addr_i = 32'h0000_1500; lk_tid_i = 1'b0;
        #1;
        chk("R2 same-cycle miss", 32'(pred_hit_o), 32'd0);
        @(negedge clk);
        fill_valid_i = 1'b0;
        #1;
        chk("R2 next-cycle hit", 32'(pred_hit_o), 32'd1);
        chk("R2 next-cycle way", 32'(pred_way_o), 32'd1);
        lk_valid_i = 1'b0;

        do_fill(32'h0000_1D00, 2'd1, 1'b0);
        look(32'h0000_1500, 1'b0, 1'b0, 2'd0, "R2 overwritten tag misses");
        look(32'h0000_1D00, 1'b0, 1'b1, 2'd1, "R2 new tag hits");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule